// File: doc/BRIEF.md
# Multi-Channel Byte-Addressable Packet Buffer

This block gives every DMA channel its own packet data store. Its write side takes a streaming frame bus. Each beat carries one full data word, a start flag, an end flag, an end position, valid/ready handshake and a metadata word. The metadata supplies the byte enables, the target channel and a doubleword write address. A beat lands at doubleword granularity: data byte `k` goes to byte address `4*A + k` of the selected channel, and the address wraps at the channel's capacity.

The read side behaves like a plain synchronous RAM port. The user presents a channel, a byte address and an enable. One clock later a full data word comes back that starts at exactly that byte. No alignment is required, and the word wraps around the end of the channel's store. To make this possible, every channel is split into one independent byte-wide lane per data byte. The write side rotates the incoming word onto the lanes. The read side picks a row per lane and rotates the lane outputs back into order.

A two-state controller handles the handshake. `ST_RESET` holds `in_dst_rdy` low. The transition `reset_done` moves to `ST_RUN` on the first clock edge with reset low. `ST_RUN` keeps the port ready through the `stay_run` transition, because every write finishes in one cycle.

Top module: `mc_byte_txbuf`

## Requirements
- R1: While `rst` is high, `in_dst_rdy` is 0 (`ST_RESET`). One clock edge after `rst` is sampled low it becomes 1 (`ST_RUN`) and stays 1 until the next reset.
- R2: A beat is written when `in_src_rdy` and `in_dst_rdy` are both 1. Data byte `k` (bits `8k+7:8k` of `in_data`) is stored in the selected channel at byte address `(4*A + k) mod 2^PTR_W`. Here `A` is the doubleword address and the store wraps at its end.
- R3: The metadata holds the byte enables in bits `[BYTES-1:0]`, the channel in the next `log2(NUM_CH)` bits, then the 62-bit doubleword address, then one spare flag bit at the top. Data byte `k` is written only when enable bit `k` is 1. Every other byte keeps its old value.
- R4: On a beat with `in_eof` = 1, 32-bit items whose index (`k/4`) is greater than `in_eof_pos` are not written, even when their enable bits are set.
- R5: When `rd_en` is sampled high, the next cycle gives `rd_data` byte `k` = the byte stored at `(rd_addr + k) mod 2^PTR_W` of channel `rd_chan`, for any byte offset.
- R6: A write to one channel never changes the contents of any other channel.
- R7: While `rd_en` is low, `rd_data` holds its last value, whatever `rd_addr` and `rd_chan` do.
- R8: A read and a write that touch the same bytes in the same cycle return the old contents. The new data is visible to the next read.
- R9: `in_sof`, `in_sof_pos`, the spare metadata flag and doubleword address bits above the store size have no effect. A beat with `in_src_rdy` = 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | ITEMS*32 | Write beat data |
| in_meta | input | ITEMS*4+log2(NUM_CH)+63 | Byte enables, channel, doubleword address, spare flag |
| in_sof | input | 1 | Start of frame (no effect) |
| in_eof | input | 1 | End of frame, enables item masking |
| in_sof_pos | input | 1 | Start position (no effect) |
| in_eof_pos | input | log2(ITEMS) | Index of the last valid item on an end beat |
| in_src_rdy | input | 1 | Write beat valid |
| in_dst_rdy | output | 1 | Write side ready |
| rd_chan | input | log2(NUM_CH) | Read channel |
| rd_addr | input | PTR_W | Read byte address |
| rd_en | input | 1 | Read enable |
| rd_data | output | ITEMS*32 | Word starting at the read byte address, one cycle later |

## Verification
The bench fills every channel of a small configuration and then reads every byte offset of every channel, so every rotation amount and every row carry is covered. A design that picked the wrong row for lanes below the start offset would return stale bytes in the upper part of unaligned words. Writes at the last doubleword and reads near the end of the store catch a missing wraparound. Random partial byte enables and each end position catch lanes that are written when they should not be. A same-cycle read and write at one address shows whether the block returns the old data or lets the new data through. Reads taken after a write to a single channel expose any write decode that spills into another channel. Beats with the start flag, the spare bit or high address bits set, and beats held without valid, show any wrong dependence on those inputs.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic {ST_RESET, ST_RUN} txb_state_e;
    localparam int DWADDR_W = 62;
endpackage

// File: rtl/txb_ctrl.sv
module txb_ctrl
    import txb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic dst_rdy
);
    txb_state_e state_q, state_d;

    // next state: reset_done moves to ST_RUN, stay_run holds it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESET;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RESET: dst_rdy = 1'b0;
            ST_RUN:   dst_rdy = 1'b1;
        endcase
    end
endmodule

// File: rtl/txb_wr_map.sv
module txb_wr_map #(
    parameter int BYTES = 32,
    parameter int PTR_W = 8,
    parameter int CH_W  = 3,
    localparam int LO_W  = $clog2(BYTES),
    localparam int ROW_W = PTR_W - LO_W,
    localparam int IDX_W = CH_W + ROW_W,
    localparam int EP_W  = LO_W - 2
) (
    input  logic                   valid,
    input  logic [BYTES*8-1:0]     data,
    input  logic [BYTES-1:0]       be,
    input  logic [CH_W-1:0]        chan,
    input  logic [PTR_W-3:0]       dw_addr,
    input  logic                   eof,
    input  logic [EP_W-1:0]        eof_pos,
    output logic [BYTES-1:0]       lane_we,
    output logic [BYTES*8-1:0]     lane_wdata,
    output logic [BYTES*IDX_W-1:0] lane_waddr
);
    logic [PTR_W-1:0] byte_addr;
    logic [LO_W-1:0]  wlo;
    logic [ROW_W-1:0] whi;

    assign byte_addr = {dw_addr, 2'b00};
    assign wlo       = byte_addr[LO_W-1:0];
    assign whi       = byte_addr[PTR_W-1:LO_W];

    for (genvar L = 0; L < BYTES; L++) begin : g_lane
        logic [LO_W-1:0]  src;
        logic [ROW_W-1:0] row;
        logic             item_ok;

        // which data byte lands in this lane, and whether it wrapped a row
        assign src     = LO_W'(L) - wlo;
        assign row     = whi + ROW_W'(LO_W'(L) < wlo);
        assign item_ok = !eof || (src[LO_W-1:2] <= eof_pos);

        assign lane_we[L]                      = valid && be[src] && item_ok;
        assign lane_wdata[L*8 +: 8]            = data[{src, 3'b000} +: 8];
        assign lane_waddr[L*IDX_W +: IDX_W]    = {chan, row};
    end
endmodule

// File: rtl/txb_lane_ram.sv
module txb_lane_ram #(
    parameter int AW = 6,
    localparam int DEPTH = 2 ** AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // read-first: the registered read sees the value before this edge's write
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/txb_rd_path.sv
module txb_rd_path #(
    parameter int BYTES = 32,
    parameter int PTR_W = 8,
    parameter int CH_W  = 3,
    localparam int LO_W  = $clog2(BYTES),
    localparam int ROW_W = PTR_W - LO_W,
    localparam int IDX_W = CH_W + ROW_W
) (
    input  logic                   clk,
    input  logic                   rd_en,
    input  logic [CH_W-1:0]        rd_chan,
    input  logic [PTR_W-1:0]       rd_addr,
    output logic [BYTES*IDX_W-1:0] lane_raddr,
    input  logic [BYTES*8-1:0]     lane_q,
    output logic [BYTES*8-1:0]     rd_data
);
    logic [LO_W-1:0]  rlo;
    logic [ROW_W-1:0] rhi;
    logic [LO_W-1:0]  lo_q;

    assign rlo = rd_addr[LO_W-1:0];
    assign rhi = rd_addr[PTR_W-1:LO_W];

    always_ff @(posedge clk) begin
        if (rd_en) lo_q <= rlo;
    end

    for (genvar L = 0; L < BYTES; L++) begin : g_row
        logic [ROW_W-1:0] row;
        // lanes below the start offset hold bytes of the following row
        assign row = rhi + ROW_W'(LO_W'(L) < rlo);
        assign lane_raddr[L*IDX_W +: IDX_W] = {rd_chan, row};
    end

    for (genvar K = 0; K < BYTES; K++) begin : g_rot
        logic [LO_W-1:0] sel;
        assign sel               = lo_q + LO_W'(K);
        assign rd_data[K*8 +: 8] = lane_q[{sel, 3'b000} +: 8];
    end
endmodule

// File: rtl/mc_byte_txbuf.sv
module mc_byte_txbuf
    import txb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ITEMS  = 8,
    parameter int PTR_W  = 8,
    localparam int BYTES  = ITEMS * 4,
    localparam int DATA_W = BYTES * 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int LO_W   = $clog2(BYTES),
    localparam int EP_W   = $clog2(ITEMS),
    localparam int ROW_W  = PTR_W - LO_W,
    localparam int IDX_W  = CH_W + ROW_W,
    localparam int META_W = BYTES + CH_W + DWADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic [META_W-1:0] in_meta,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_sof_pos,
    input  logic [EP_W-1:0]   in_eof_pos,
    input  logic              in_src_rdy,
    output logic              in_dst_rdy,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic [PTR_W-1:0]  rd_addr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [BYTES-1:0]       lane_we;
    logic [DATA_W-1:0]      lane_wdata;
    logic [BYTES*IDX_W-1:0] lane_waddr;
    logic [BYTES*IDX_W-1:0] lane_raddr;
    logic [DATA_W-1:0]      lane_q;
    logic                   unused_inputs;

    assign unused_inputs = ^{in_sof, in_sof_pos, in_meta[META_W-1],
                             in_meta[BYTES+CH_W+PTR_W-2 +: DWADDR_W-(PTR_W-2)]};

    txb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .dst_rdy (in_dst_rdy)
    );

    txb_wr_map #(.BYTES(BYTES), .PTR_W(PTR_W), .CH_W(CH_W)) u_wr (
        .valid      (in_src_rdy && in_dst_rdy),
        .data       (in_data),
        .be         (in_meta[BYTES-1:0]),
        .chan       (in_meta[BYTES +: CH_W]),
        .dw_addr    (in_meta[BYTES+CH_W +: PTR_W-2]),
        .eof        (in_eof),
        .eof_pos    (in_eof_pos),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .lane_waddr (lane_waddr)
    );

    for (genvar L = 0; L < BYTES; L++) begin : g_store
        txb_lane_ram #(.AW(IDX_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[L]),
            .waddr (lane_waddr[L*IDX_W +: IDX_W]),
            .wdata (lane_wdata[L*8 +: 8]),
            .re    (rd_en),
            .raddr (lane_raddr[L*IDX_W +: IDX_W]),
            .rdata (lane_q[L*8 +: 8])
        );
    end

    txb_rd_path #(.BYTES(BYTES), .PTR_W(PTR_W), .CH_W(CH_W)) u_rd (
        .clk        (clk),
        .rd_en      (rd_en),
        .rd_chan    (rd_chan),
        .rd_addr    (rd_addr),
        .lane_raddr (lane_raddr),
        .lane_q     (lane_q),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
    parameter int DATA_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_dst_rdy,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data
);
    // R1: ready low in the cycle after reset is sampled
    a_r1_low_in_reset: assert property (@(posedge clk)
        rst |=> !in_dst_rdy);

    // R1: ready rises one edge after reset is released
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        !rst |=> in_dst_rdy);

    // R1: ready never drops outside reset
    a_r1_ready_stays: assert property (@(posedge clk) disable iff (rst)
        in_dst_rdy |=> in_dst_rdy);

    // R7: output word holds while no read is issued
    a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind mc_byte_txbuf txb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_dst_rdy (in_dst_rdy),
    .rd_en      (rd_en),
    .rd_data    (rd_data)
);

// File: tb/test_mc_byte_txbuf.sv
module test_mc_byte_txbuf;
    localparam int NCH = 4;
    localparam int ITEMS = 4;
    localparam int PW = 6;
    localparam int BY = ITEMS * 4;
    localparam int DW = BY * 8;
    localparam int CHW = 2;
    localparam int MW = BY + CHW + 63;
    localparam int CAP = 1 << PW;
    localparam int NDW = CAP / 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic [DW-1:0] in_data;
    logic [MW-1:0] in_meta;
    logic          in_sof, in_eof, in_sof_pos, in_src_rdy, in_dst_rdy;
    logic [1:0]    in_eof_pos;
    logic [CHW-1:0] rd_chan;
    logic [PW-1:0] rd_addr;
    logic          rd_en;
    logic [DW-1:0] rd_data;

    logic [7:0] model [NCH][CAP];
    int total = 0;
    int bad = 0;
    int unsigned seed = 32'h1234_5678;
    bit done = 0;

    mc_byte_txbuf #(.NUM_CH(NCH), .ITEMS(ITEMS), .PTR_W(PW)) i_mc_byte_txbuf (
        .clk(clk), .rst(rst), .in_data(in_data), .in_meta(in_meta),
        .in_sof(in_sof), .in_eof(in_eof), .in_sof_pos(in_sof_pos),
        .in_eof_pos(in_eof_pos), .in_src_rdy(in_src_rdy), .in_dst_rdy(in_dst_rdy),
        .rd_chan(rd_chan), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [DW-1:0] mkdata();
        logic [DW-1:0] r;
        for (int k = 0; k < BY; k++) r[k*8 +: 8] = 8'(rnd());
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_word(int ch, int addr);
        logic [DW-1:0] r;
        for (int k = 0; k < BY; k++) r[k*8 +: 8] = model[ch][(addr + k) % CAP];
        return r;
    endfunction

    function automatic void apply_wr(int ch, longint unsigned a, logic [DW-1:0] d,
                                     logic [BY-1:0] be, logic eof, int ep);
        int base;
        base = int'(a % NDW) * 4;
        for (int k = 0; k < BY; k++)
            if (be[k] && (!eof || (k / 4) <= ep))
                model[ch][(base + k) % CAP] = d[k*8 +: 8];
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_word(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_beat(int ch, longint unsigned a, logic [DW-1:0] d, logic [BY-1:0] be,
                            logic eof, int ep, logic sof, logic flag, logic vld);
        in_data    = d;
        in_meta    = {flag, a[61:0], CHW'(ch), be};
        in_eof     = eof;
        in_eof_pos = 2'(ep);
        in_sof     = sof;
        in_sof_pos = sof;
        in_src_rdy = vld;
    endtask

    task automatic wr(int ch, longint unsigned a, logic [DW-1:0] d, logic [BY-1:0] be,
                      logic eof, int ep);
        put_beat(ch, a, d, be, eof, ep, 1'b0, 1'b0, 1'b1);
        step();
        in_src_rdy = 1'b0;
        apply_wr(ch, a, d, be, eof, ep);
    endtask

    task automatic rd_check(int ch, int addr, string tag);
        rd_en   = 1'b1;
        rd_chan = CHW'(ch);
        rd_addr = PW'(addr);
        step();
        rd_en = 1'b0;
        check_word(tag, rd_data, exp_word(ch, addr));
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] held;
        rst = 1'b1; rd_en = 1'b0; rd_chan = '0; rd_addr = '0;
        put_beat(0, 0, '0, '0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        repeat (3) step();
        check_word("R1 ready low in reset", DW'(in_dst_rdy), DW'(0));
        rst = 1'b0;
        check_word("R1 ready low at release", DW'(in_dst_rdy), DW'(0));
        step();
        check_word("R1 ready high after release", DW'(in_dst_rdy), DW'(1));

        // fill every doubleword of every channel
        for (int c = 0; c < NCH; c++)
            for (int a = 0; a < NDW; a++) wr(c, longint'(a), mkdata(), '1, 1'b0, 0);
        // R5: every channel at every byte offset
        for (int c = 0; c < NCH; c++)
            for (int a = 0; a < CAP; a++) rd_check(c, a, "R5 unaligned read");
        check_word("R1 ready stays high", DW'(in_dst_rdy), DW'(1));

        // R3: random partial byte enables
        for (int i = 0; i < 48; i++)
            wr(int'(rnd() % NCH), longint'(rnd() % NDW), mkdata(), BY'(rnd()), 1'b0, 0);
        for (int c = 0; c < NCH; c++)
            for (int a = 0; a < CAP; a += 3) rd_check(c, a, "R3 byte enables");

        // R4: end-of-frame item masking at every position
        for (int ep = 0; ep < ITEMS; ep++) begin
            wr(1, longint'(4 + ep), mkdata(), '1, 1'b1, ep);
            rd_check(1, (4 + ep) * 4, "R4 eof mask");
        end

        // R2: last doubleword wraps to the start of the store
        wr(2, longint'(NDW - 1), mkdata(), '1, 1'b0, 0);
        rd_check(2, CAP - 4, "R2 write wrap");
        rd_check(2, 0, "R2 write wrap low");
        rd_check(2, CAP - 1, "R5 read wrap");

        // R9: high address bits, start flag and spare bit have no effect
        d = mkdata();
        put_beat(3, (64'd1 << 40) + 64'd5, d, '1, 1'b0, 0, 1'b1, 1'b1, 1'b1);
        step();
        in_src_rdy = 1'b0;
        apply_wr(3, 64'd5, d, '1, 1'b0, 0);
        rd_check(3, 20, "R9 ignored fields");
        // R9: beat without valid writes nothing
        put_beat(3, 64'd5, mkdata(), '1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        step();
        rd_check(3, 20, "R9 no write without valid");

        // R8: same-cycle read and write returns old data
        d = mkdata();
        put_beat(0, 64'd9, d, '1, 1'b0, 0, 1'b0, 1'b0, 1'b1);
        rd_en = 1'b1; rd_chan = 2'd0; rd_addr = PW'(36);
        step();
        rd_en = 1'b0; in_src_rdy = 1'b0;
        check_word("R8 read-first old data", rd_data, exp_word(0, 36));
        apply_wr(0, 64'd9, d, '1, 1'b0, 0);
        rd_check(0, 36, "R8 new data next read");

        // R6: a write to channel 2 leaves the others intact
        for (int a = 0; a < NDW; a++) wr(2, longint'(a), mkdata(), '1, 1'b0, 0);
        for (int c = 0; c < NCH; c++)
            if (c != 2)
                for (int a = 0; a < CAP; a += 2) rd_check(c, a, "R6 channel isolation");

        // R7: output holds while rd_en is low
        rd_check(1, 7, "R5 read before hold");
        held = exp_word(1, 7);
        rd_chan = 2'd3; rd_addr = PW'(50);
        repeat (3) step();
        check_word("R7 hold without read", rd_data, held);

        finish_up();
    end
endmodule